// File: doc/BRIEF.md
# Channel byte interrupt detector

This block watches a stream of time-slot bytes and raises an interrupt when the byte in a chosen slot meets a programmed condition. The bytes arrive one slot per strobe, each tagged with its slot number. There are two independent interrupt paths. Each path has its own slot address, match byte, mask byte, mode bit and enable bit. A path in static mode compares the slot byte with the match byte, skipping the bits that the mask excludes. A path in dynamic mode looks for bit edges. For each bit, the match bit and the mask bit together select which kind of edge counts.

Each path runs a two-state machine with the states `S_IDLE` and `S_PEND`. The transition `arm→pend` is taken when a qualifying slot byte hits the condition. The transition `pend→arm` is taken when the path is serviced or cleared. While a path is pending, its image register holds the triggering byte. A dynamic path also collects the hit bit positions in a flag register, and reading that register clears it. An acknowledge input puts a vector byte on the read bus. The low two bits of that byte show which enabled paths are pending. A clear bit in the control register resets the image registers, the flag registers and both machines in a single write.

Top module: `chan_irq_detect`

## Requirements
- R1: After reset, `irq` is 0 and every register (selects 0 to 11) reads 0.
- R2: Register selects are: 0 control, 1 vector base, 2/3/4/5/6 path-1 address/match/mask/image/flags, 7/8/9/10/11 path-2 address/match/mask/image/flags. Control bits are: bit 0 path-1 mode, bit 1 path-2 mode (1 = dynamic, 0 = static), bit 2 path-1 enable, bit 3 path-2 enable, bit 7 clear. A value written to a writable register reads back unchanged, except that control bit 7 always reads 0.
- R3: In static mode, a mask bit of 1 excludes that bit from the compare. The path goes pending only on the slot where all unmasked bits first equal the match byte. Further matching slots do not fire it again until a non-matching slot has been seen.
- R4: While a path is pending, its image register holds the byte that triggered it. In static mode, reading the image register clears the pending state.
- R5: In dynamic mode, bit x hits on the condition selected by {match[x], mask[x]}: 00 is a 0-to-1 edge, 01 is a 1-to-0 edge, 10 never hits, and 11 is either edge. The edge is taken between consecutive bytes of the selected slot.
- R6: In dynamic mode, every hit bit sets the flag bit at the same position, and the path goes pending. Reading the flag register returns the flags, clears them to 0 and clears the pending state.
- R7: Only slots whose number equals a path's address affect that path.
- R8: `irq` is the OR over both paths of pending AND enable. A pending state is kept while its enable is 0.
- R9: While `iack` is 1, `rd_data` is {vector base[7:2], path-2 pending&enable, path-1 pending&enable}, and no register is cleared.
- R10: Writing control with bit 7 set clears both image registers, both flag registers and both pending states.
- R11: The two paths work independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_vld | input | 1 | Slot byte strobe |
| slot_num | input | CH_W | Slot number of the byte |
| slot_data | input | DATA_W | Slot byte |
| cfg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe (clears image or flags when those are selected) |
| iack | input | 1 | Interrupt acknowledge, selects the vector byte |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The dynamic condition is run from a table of match, mask, previous and current bytes. The table covers each of the four codes applied to all bits and one mixed row that has all four codes at once, so it separates a swapped rising or falling decode, a leaking masked code and a one-sided toggle. Static mode is tried with a byte that matches only through masked bits, a repeated match and a mismatch. Together these show whether the mask is honoured and whether the path fires on the first matching slot only. Acknowledge, enable gating, the second path on another slot, and the clear bit are each checked with directed sequences.

// File: rtl/cid_pkg.sv
package cid_pkg;
    typedef enum logic [3:0] {
        SEL_CTRL = 4'd0,  SEL_VEC  = 4'd1,
        SEL_ADR1 = 4'd2,  SEL_MAT1 = 4'd3, SEL_MSK1 = 4'd4, SEL_IMG1 = 4'd5, SEL_FLG1 = 4'd6,
        SEL_ADR2 = 4'd7,  SEL_MAT2 = 4'd8, SEL_MSK2 = 4'd9, SEL_IMG2 = 4'd10, SEL_FLG2 = 4'd11
    } reg_sel_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_PEND = 1'b1
    } path_st_e;

    localparam int NPATH    = 2;
    localparam int SEL_STEP = 5;
    localparam int CLR_BIT  = 7;
endpackage

// File: rtl/cid_cond.sv
module cid_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] match_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] dyn_hit_o,
    output logic         stat_eq_o
);
    logic [W-1:0] bit_ok;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            unique case ({match_i[b], mask_i[b]})
                2'b00:   dyn_hit_o[b] = ~prev_i[b] &  cur_i[b];
                2'b01:   dyn_hit_o[b] =  prev_i[b] & ~cur_i[b];
                2'b10:   dyn_hit_o[b] = 1'b0;
                default: dyn_hit_o[b] =  prev_i[b] ^  cur_i[b];
            endcase
        end
        assign bit_ok[b] = mask_i[b] | ~(cur_i[b] ^ match_i[b]);
    end

    assign stat_eq_o = &bit_ok;
endmodule

// File: rtl/cid_path.sv
module cid_path
    import cid_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          dyn_i,
    input  logic [CW-1:0] addr_i,
    input  logic [W-1:0]  match_i,
    input  logic [W-1:0]  mask_i,
    input  logic          slot_vld_i,
    input  logic [CW-1:0] slot_num_i,
    input  logic [W-1:0]  slot_data_i,
    input  logic          rd_img_i,
    input  logic          rd_flag_i,
    output logic          pend_o,
    output logic [W-1:0]  img_o,
    output logic [W-1:0]  flag_o
);
    path_st_e     st_q, st_d;
    logic [W-1:0] prev_q, img_q, flag_q, dyn_hit;
    logic         last_eq_q, stat_eq, sel, hit, svc;

    assign sel = slot_vld_i && (slot_num_i == addr_i);
    assign svc = dyn_i ? rd_flag_i : rd_img_i;

    cid_cond #(.W(W)) u_cond (
        .prev_i   (prev_q),
        .cur_i    (slot_data_i),
        .match_i  (match_i),
        .mask_i   (mask_i),
        .dyn_hit_o(dyn_hit),
        .stat_eq_o(stat_eq)
    );

    assign hit = dyn_i ? (|dyn_hit) : (stat_eq && !last_eq_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (!clr_i && sel && hit) st_d = S_PEND;   // arm->pend
            S_PEND: if (clr_i || svc)         st_d = S_IDLE;   // pend->arm
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            last_eq_q <= 1'b0;
            img_q     <= '0;
            flag_q    <= '0;
        end else begin
            if (sel) begin
                prev_q    <= slot_data_i;
                last_eq_q <= stat_eq;
            end
            if (clr_i)                      img_q <= '0;
            else if (st_q == S_IDLE && sel) img_q <= slot_data_i;
            if (clr_i || rd_flag_i)         flag_q <= '0;
            else if (dyn_i && sel)          flag_q <= flag_q | dyn_hit;
        end
    end

    assign pend_o = (st_q == S_PEND);
    assign img_o  = img_q;
    assign flag_o = flag_q;

    // R4
    img_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PEND && !clr_i) |=> $stable(img_q));
    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q == S_IDLE && img_q == '0 && flag_q == '0));
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flag_i |=> (flag_q == '0));
    // R3
    stat_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !dyn_i && sel && stat_eq && !last_eq_q && !clr_i) |=> (st_q == S_PEND));
endmodule

// File: rtl/chan_irq_detect.sv
module chan_irq_detect
    import cid_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_vld,
    input  logic [CH_W-1:0]   slot_num,
    input  logic [DATA_W-1:0] slot_data,
    input  logic              cfg_we,
    input  logic [3:0]        reg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rd_en,
    input  logic              iack,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int VB_W = DATA_W - NPATH;

    logic [NPATH-1:0]             mode_q, en_q, pend, path_bits;
    logic [VB_W-1:0]              vbase_q;
    logic [NPATH-1:0][CH_W-1:0]   addr_q;
    logic [NPATH-1:0][DATA_W-1:0] match_q, mask_q, img, flag;
    logic                         clr;

    assign clr = cfg_we && (reg_sel == SEL_CTRL) && cfg_wdata[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            en_q    <= '0;
            vbase_q <= '0;
            addr_q  <= '0;
            match_q <= '0;
            mask_q  <= '0;
        end else if (cfg_we) begin
            if (reg_sel == SEL_CTRL) begin
                mode_q <= cfg_wdata[1:0];
                en_q   <= cfg_wdata[3:2];
            end
            if (reg_sel == SEL_VEC) vbase_q <= cfg_wdata[DATA_W-1:NPATH];
            for (int p = 0; p < NPATH; p++) begin
                if (reg_sel == 4'(SEL_ADR1 + p*SEL_STEP)) addr_q[p]  <= cfg_wdata[CH_W-1:0];
                if (reg_sel == 4'(SEL_MAT1 + p*SEL_STEP)) match_q[p] <= cfg_wdata;
                if (reg_sel == 4'(SEL_MSK1 + p*SEL_STEP)) mask_q[p]  <= cfg_wdata;
            end
        end
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic rd_img, rd_flag;
        assign rd_img  = rd_en && !iack && (reg_sel == 4'(SEL_IMG1 + p*SEL_STEP));
        assign rd_flag = rd_en && !iack && (reg_sel == 4'(SEL_FLG1 + p*SEL_STEP));

        cid_path #(.W(DATA_W), .CW(CH_W)) u_path (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (clr),
            .dyn_i      (mode_q[p]),
            .addr_i     (addr_q[p]),
            .match_i    (match_q[p]),
            .mask_i     (mask_q[p]),
            .slot_vld_i (slot_vld),
            .slot_num_i (slot_num),
            .slot_data_i(slot_data),
            .rd_img_i   (rd_img),
            .rd_flag_i  (rd_flag),
            .pend_o     (pend[p]),
            .img_o      (img[p]),
            .flag_o     (flag[p])
        );
    end

    assign path_bits = pend & en_q;
    assign irq       = |path_bits;

    always_comb begin
        rd_data = '0;
        if (iack) begin
            rd_data = {vbase_q, path_bits};
        end else begin
            unique case (reg_sel)
                SEL_CTRL: rd_data = DATA_W'({en_q, mode_q});
                SEL_VEC:  rd_data = {vbase_q, {NPATH{1'b0}}};
                SEL_ADR1: rd_data = DATA_W'(addr_q[0]);
                SEL_MAT1: rd_data = match_q[0];
                SEL_MSK1: rd_data = mask_q[0];
                SEL_IMG1: rd_data = img[0];
                SEL_FLG1: rd_data = flag[0];
                SEL_ADR2: rd_data = DATA_W'(addr_q[1]);
                SEL_MAT2: rd_data = match_q[1];
                SEL_MSK2: rd_data = mask_q[1];
                SEL_IMG2: rd_data = img[1];
                SEL_FLG2: rd_data = flag[1];
                default:  rd_data = '0;
            endcase
        end
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
    // R9
    ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !cfg_we && (pend != '0)) |=> (pend != '0));
endmodule

// File: tb/chan_irq_detect_test.sv
module chan_irq_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_vld = 1'b0;
    logic [4:0] slot_num = '0;
    logic [7:0] slot_data = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rd_en = 1'b0;
    logic       iack = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chan_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_num(slot_num),
        .slot_data(slot_data), .cfg_we(cfg_we), .reg_sel(reg_sel),
        .cfg_wdata(cfg_wdata), .rd_en(rd_en), .iack(iack),
        .rd_data(rd_data), .irq(irq)
    );

    // {match, mask, previous byte, current byte, expected flags}
    localparam logic [39:0] DYN_TAB [0:5] = '{
        40'h00_00_00_FF_FF,
        40'h00_FF_FF_00_FF,
        40'hFF_00_FF_00_00,
        40'hFF_FF_0F_F0_FF,
        40'h00_00_FF_00_00,
        40'hF0_CC_5A_A5_C9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_slot(input logic [4:0] n, input logic [7:0] d);
        @(negedge clk);
        slot_vld = 1'b1; slot_num = n; slot_data = d;
        @(negedge clk);
        slot_vld = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; reg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = s;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack(output logic [7:0] d);
        @(negedge clk);
        iack = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        iack = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        for (int s = 0; s < 12; s++) begin
            rd(4'(s), v);
            check("R1 reg", v, 8'h00);
        end

        // R2: readback, clear bit reads 0
        wr(4'd8, 8'h3C); rd(4'd8, v); check("R2 match2", v, 8'h3C);
        wr(4'd1, 8'hA8); rd(4'd1, v); check("R2 vector", v, 8'hA8);
        wr(4'd0, 8'h85); rd(4'd0, v); check("R2 ctrl", v, 8'h05);
        wr(4'd2, 8'h07); rd(4'd2, v); check("R2 addr1", v, 8'h07);

        // R5 / R6: dynamic table walk on path 1, slot 7
        for (int i = 0; i < 6; i++) begin
            wr(4'd3, DYN_TAB[i][39:32]);
            wr(4'd4, DYN_TAB[i][31:24]);
            put_slot(5'd7, DYN_TAB[i][23:16]);
            wr(4'd0, 8'h85);
            put_slot(5'd7, DYN_TAB[i][15:8]);
            check("R5 irq", {7'b0, irq}, {7'b0, DYN_TAB[i][7:0] != 8'h00});
            rd(4'd6, v);
            check("R5/R6 flags", v, DYN_TAB[i][7:0]);
            check("R6 irq after read", {7'b0, irq}, 8'h00);
            rd(4'd6, v);
            check("R6 flags cleared", v, 8'h00);
        end
        wr(4'd0, 8'h80);

        // R3 / R4 / R7 / R9: static path 1 on slot 3
        wr(4'd2, 8'h03); wr(4'd3, 8'hA5); wr(4'd4, 8'h0F); wr(4'd0, 8'h04);
        put_slot(5'd4, 8'hA5);
        check("R7 other slot", {7'b0, irq}, 8'h00);
        put_slot(5'd3, 8'hA0);
        check("R3 masked match", {7'b0, irq}, 8'h01);
        ack(v);
        check("R9 vector", v, 8'hA9);
        check("R9 ack keeps irq", {7'b0, irq}, 8'h01);
        put_slot(5'd3, 8'hA3);
        rd(4'd5, v);
        check("R4 frozen image", v, 8'hA0);
        check("R4 irq after read", {7'b0, irq}, 8'h00);
        put_slot(5'd3, 8'hA7);
        check("R3 no refire", {7'b0, irq}, 8'h00);
        put_slot(5'd3, 8'h55);
        check("R3 mismatch", {7'b0, irq}, 8'h00);
        put_slot(5'd3, 8'hAF);
        check("R3 refire", {7'b0, irq}, 8'h01);
        rd(4'd5, v);
        check("R4 image", v, 8'hAF);

        // R8 / R11: path 2 dynamic on slot 9 with enable off
        wr(4'd0, 8'h80);
        wr(4'd7, 8'h09); wr(4'd8, 8'h00); wr(4'd9, 8'h00);
        wr(4'd0, 8'h06);
        put_slot(5'd9, 8'h01);
        check("R8 gated", {7'b0, irq}, 8'h00);
        ack(v);
        check("R11 path1 quiet", v, 8'hA8);
        wr(4'd0, 8'h0E);
        check("R8 held pending", {7'b0, irq}, 8'h01);
        ack(v);
        check("R11 path2 bit", v, 8'hAA);
        rd(4'd11, v);
        check("R11 flags2", v, 8'h01);
        check("R6 irq cleared", {7'b0, irq}, 8'h00);

        // R10: clear bit
        wr(4'd0, 8'h04);
        put_slot(5'd3, 8'h00);
        put_slot(5'd3, 8'hA5);
        check("R10 fired", {7'b0, irq}, 8'h01);
        wr(4'd0, 8'h84);
        check("R10 irq", {7'b0, irq}, 8'h00);
        rd(4'd5, v);
        check("R10 image", v, 8'h00);
        rd(4'd0, v);
        check("R10 ctrl", v, 8'h04);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule